// File: doc/BRIEF.md
# Rotated-Byte Immediate Operand Expander

This block sits in the decode stage of a core that uses 32-bit instruction words. It looks at one word and reports three things. The first is whether the word belongs to the data-processing class. The second is the 4-bit operation code. The third is whether the second operand is an immediate.

When the second operand is an immediate, the block turns the 12-bit operand field into a full 32-bit constant. The low byte of the field is zero-extended to the word width. It is then rotated right by twice the 4-bit count held in the upper part of the field. The constant can therefore be any byte placed at an even rotation, including placements that wrap across bit 31 into bit 0.

All results are registered and appear one cycle after the input strobe. When the operand is not an immediate, the constant output is held at zero so that downstream logic can use it without qualification.

Top module: `rbx_imm_expander`

## Requirements
- R1: `out_is_dp` is 1 exactly when bits 27 and 26 of the captured word are both 0.
- R2: `out_opcode` equals bits 24 down to 21 of the captured word, whatever class the word has.
- R3: `out_is_imm` is 1 exactly when the word is data processing (R1) and bit 25 of the word is 1.
- R4: When `out_is_imm` is 1, `out_imm` equals bits 7:0 zero-extended to 32 bits, rotated right by 2 × bits 11:8. The rotate amount is one of the even values 0 to 30.
- R5: A rotation that wraps the byte across the word boundary places its low bits at the top of the word. For example, field 0x1D3 gives 0xC0000034, and field 0x102 gives 0x80000000.
- R6: When `out_is_imm` is 0, `out_imm` is 0. This holds both for register-operand words and for words outside the data-processing class.
- R7: `out_valid` is `in_valid` delayed by exactly one clock cycle. The other outputs take the values of the word presented with that strobe.
- R8: While `in_valid` is 0, `out_imm`, `out_opcode`, `out_is_imm` and `out_is_dp` keep their previous values, whatever `in_word` carries.
- R9: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Results below belong to a word accepted one cycle earlier |
| out_imm | output | 32 | Expanded constant, zero unless immediate |
| out_opcode | output | 4 | Operation code field |
| out_is_imm | output | 1 | Second operand is an immediate |
| out_is_dp | output | 1 | Word is in the data-processing class |

## Verification
Every one of the 4096 operand-field values is expanded and compared with a rotate computed in the bench. Two kinds of mistake are most likely to show up on the large and odd counts. A rotator that shifts instead of rotating would lose the wrapped bits of 0xC0000034. One that rotates by the count instead of twice the count would put most constants in the wrong place.

Words outside the data-processing class are tried with bit 25 set. A decoder that trusted bit 25 alone would then raise the immediate flag and leak a non-zero constant. The remaining checks cover the strobe and reset behaviour. Changing the word while the strobe is low catches a register that loads every cycle. A reset in the middle of traffic catches outputs that are not cleared.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

   // Field positions that the rest of the pipeline also decodes
   localparam int CLASS_HI   = 27;
   localparam int CLASS_LO   = 26;
   localparam int IMM_SEL    = 25;
   localparam int OPC_HI     = 24;
   localparam int OPC_LO     = 21;
   localparam int OPC_W      = OPC_HI - OPC_LO + 1;

   // Rotator variants
   localparam int ROT_IMPL_STAGED = 0;
   localparam int ROT_IMPL_MUX    = 1;

   typedef struct packed {
      logic             is_dp;
      logic             is_imm;
      logic [OPC_W-1:0] opcode;
   } rbx_dec_t;

endpackage

// File: rtl/rbx_class_decode.sv
module rbx_class_decode
   import rbx_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word_i,
   output rbx_dec_t          dec_o
);

   always_comb begin
      dec_o.is_dp  = (word_i[CLASS_HI:CLASS_LO] == 2'b00);
      dec_o.is_imm = dec_o.is_dp & word_i[IMM_SEL];
      dec_o.opcode = word_i[OPC_HI:OPC_LO];
   end

endmodule

// File: rtl/rbx_rotator.sv
module rbx_rotator
   import rbx_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int ROT_W    = 4,
   parameter int ROT_STEP = 2,
   parameter int ROT_IMPL = ROT_IMPL_STAGED
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [ROT_W-1:0]  cnt_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int NPOS = 1 << ROT_W;

   logic [WORD_W-1:0] seed;
   assign seed = {{(WORD_W-BYTE_W){1'b0}}, byte_i};

   function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x,
                                               input int unsigned amt);
      logic [2*WORD_W-1:0] dbl;
      dbl = {x, x} >> amt;
      return dbl[WORD_W-1:0];
   endfunction

   generate
      if (ROT_IMPL == ROT_IMPL_STAGED) begin : g_staged
         logic [WORD_W-1:0] stage [ROT_W+1];
         assign stage[0] = seed;
         for (genvar k = 0; k < ROT_W; k++) begin : g_lvl
            localparam int AMT = ROT_STEP << k;
            assign stage[k+1] = cnt_i[k] ?
               {stage[k][AMT-1:0], stage[k][WORD_W-1:AMT]} : stage[k];
         end
         assign word_o = stage[ROT_W];
      end else begin : g_mux
         logic [WORD_W-1:0] cand [NPOS];
         for (genvar p = 0; p < NPOS; p++) begin : g_pos
            assign cand[p] = rotr(seed, p * ROT_STEP);
         end
         assign word_o = cand[cnt_i];
      end
   endgenerate

endmodule

// File: rtl/rbx_imm_expander.sv
module rbx_imm_expander
   import rbx_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int ROT_W    = 4,
   parameter int ROT_STEP = 2,
   parameter int ROT_IMPL = ROT_IMPL_STAGED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_word,
   output logic              out_valid,
   output logic [31:0]       out_imm,
   output logic [3:0]        out_opcode,
   output logic              out_is_imm,
   output logic              out_is_dp
);

   localparam int FIELD_W = BYTE_W + ROT_W;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("rbx_imm_expander: WORD_W must be 32");
      end
      if (ROT_STEP * (1 << ROT_W) != WORD_W) begin : g_bad_rot
         $error("rbx_imm_expander: rotate steps must cover the word exactly");
      end
      if (FIELD_W > OPC_LO) begin : g_bad_field
         $error("rbx_imm_expander: operand field overlaps the opcode");
      end
      if (ROT_IMPL != ROT_IMPL_STAGED && ROT_IMPL != ROT_IMPL_MUX) begin : g_bad_impl
         $error("rbx_imm_expander: unknown ROT_IMPL");
      end
   endgenerate

   rbx_dec_t          dec;
   logic [WORD_W-1:0] rot_val;
   logic [WORD_W-1:0] imm_next;

   rbx_class_decode #(.WORD_W(WORD_W)) u_dec (
      .word_i (in_word),
      .dec_o  (dec)
   );

   rbx_rotator #(
      .WORD_W   (WORD_W),
      .BYTE_W   (BYTE_W),
      .ROT_W    (ROT_W),
      .ROT_STEP (ROT_STEP),
      .ROT_IMPL (ROT_IMPL)
   ) u_rot (
      .byte_i (in_word[BYTE_W-1:0]),
      .cnt_i  (in_word[FIELD_W-1:BYTE_W]),
      .word_o (rot_val)
   );

   assign imm_next = dec.is_imm ? rot_val : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_imm    <= '0;
         out_opcode <= '0;
         out_is_imm <= 1'b0;
         out_is_dp  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_imm    <= imm_next;
            out_opcode <= dec.opcode;
            out_is_imm <= dec.is_imm;
            out_is_dp  <= dec.is_dp;
         end
      end
   end

endmodule

// File: rtl/rbx_imm_expander_chk.sv
module rbx_imm_expander_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_word,
   input logic        out_valid,
   input logic [31:0] out_imm,
   input logic [3:0]  out_opcode,
   input logic        out_is_imm,
   input logic        out_is_dp
);

   assert_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_is_dp == ($past(in_word[27:26]) == 2'b00)));

   assert_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_opcode == $past(in_word[24:21])));

   assert_imm_needs_dp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_imm |-> out_is_dp);

   assert_byte_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_imm) <= 8);

   assert_zero_when_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_is_imm |-> (out_imm == 32'd0));

   assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_imm) && $stable(out_opcode) &&
                     $stable(out_is_imm) && $stable(out_is_dp)));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R9: assert (!out_valid && out_imm == 32'd0 &&
                                  out_opcode == 4'd0 && !out_is_imm && !out_is_dp);
      end
   end

endmodule

bind rbx_imm_expander rbx_imm_expander_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_word    (in_word),
   .out_valid  (out_valid),
   .out_imm    (out_imm),
   .out_opcode (out_opcode),
   .out_is_imm (out_is_imm),
   .out_is_dp  (out_is_dp)
);

// File: tb/rbx_imm_expander_test.sv
`timescale 1ns/1ps
module rbx_imm_expander_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = 32'd0;
   logic        out_valid;
   logic [31:0] out_imm;
   logic [3:0]  out_opcode;
   logic        out_is_imm;
   logic        out_is_dp;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   rbx_imm_expander uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .out_valid  (out_valid),
      .out_imm    (out_imm),
      .out_opcode (out_opcode),
      .out_is_imm (out_is_imm),
      .out_is_dp  (out_is_dp)
   );

   // word, expected constant, expected dp flag, expected immediate flag
   localparam int NVEC = 9;
   localparam logic [65:0] VEC [NVEC] = '{
      {32'hE3A004FF, 32'hFF000000, 1'b1, 1'b1},
      {32'hE3A001D3, 32'hC0000034, 1'b1, 1'b1},
      {32'hE3A000FF, 32'h000000FF, 1'b1, 1'b1},
      {32'hE3A00F01, 32'h00000004, 1'b1, 1'b1},
      {32'hE3A00102, 32'h80000000, 1'b1, 1'b1},
      {32'h02000BFF, 32'h0003FC00, 1'b1, 1'b1},
      {32'hE1A004FF, 32'h00000000, 1'b1, 1'b0},
      {32'hE5900FFF, 32'h00000000, 1'b0, 1'b0},
      {32'hEA0000FF, 32'h00000000, 1'b0, 1'b0}
   };

   function automatic logic [31:0] ref_imm(input logic [11:0] f);
      logic [63:0] d;
      d = {24'd0, f[7:0], 24'd0, f[7:0]} >> (2 * f[11:8]);
      return d[31:0];
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, check at the following negedge (one register)
   task automatic apply(input logic [31:0] w);
      in_word  = w;
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(out_valid == 0 && out_imm == 0 && out_opcode == 0 &&
            !out_is_imm && !out_is_dp, "R9 reset",
            {out_valid, out_is_imm, out_is_dp, 25'd0, out_opcode}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][65:34]);
         check(out_imm == VEC[i][33:2], "R4/R5/R6 table constant", out_imm, VEC[i][33:2]);
         check(out_is_dp == VEC[i][1], "R1 table class", {31'd0, out_is_dp}, {31'd0, VEC[i][1]});
         check(out_is_imm == VEC[i][0], "R3 table imm flag", {31'd0, out_is_imm}, {31'd0, VEC[i][0]});
         check(out_opcode == VEC[i][65-7 -: 4], "R2 table opcode",
               {28'd0, out_opcode}, {28'd0, VEC[i][58:55]});
         check(out_valid == 1'b1, "R7 valid follows", {31'd0, out_valid}, 32'd1);
      end

      // exhaustive field sweep: R4, R2
      for (int f = 0; f < 4096; f++) begin
         logic [31:0] w;
         logic [3:0]  op;
         op = 4'(f % 16);
         w  = {4'hE, 2'b00, 1'b1, op, 1'b0, 8'h00, 12'(f)};
         apply(w);
         check(out_imm == ref_imm(12'(f)), "R4 sweep constant", out_imm, ref_imm(12'(f)));
         if (f % 256 == 0)
            check(out_opcode == op, "R2 sweep opcode", {28'd0, out_opcode}, {28'd0, op});
      end

      // R6: non-dp word with bit 25 set and a rich field
      apply(32'hEE1A0FFF);
      check(out_imm == 0 && !out_is_imm && !out_is_dp, "R6 non-dp leak",
            out_imm, 32'd0);
      check(out_opcode == 4'h0, "R2 opcode non-dp", {28'd0, out_opcode}, 32'd0);

      // R8 / R7: hold while strobe is low
      apply(32'hE3A001D3);
      in_valid = 1'b0;
      in_word  = 32'h0380F0FF;
      @(negedge clk);
      check(out_valid == 1'b0, "R7 valid drops", {31'd0, out_valid}, 32'd0);
      check(out_imm == 32'hC0000034, "R8 constant held", out_imm, 32'hC0000034);
      check(out_opcode == 4'hD && out_is_imm && out_is_dp, "R8 fields held",
            {28'd0, out_opcode}, 32'hD);
      @(negedge clk);
      check(out_imm == 32'hC0000034, "R8 constant still held", out_imm, 32'hC0000034);

      // R9: reset in the middle of traffic
      apply(32'hE3A004FF);
      in_valid = 1'b1;
      rst_n    = 1'b0;
      #1;
      check(out_valid == 0 && out_imm == 0 && out_opcode == 0 &&
            !out_is_imm && !out_is_dp, "R9 mid-run reset",
            out_imm, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0, "R7 no valid after reset", {31'd0, out_valid}, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule